// File: doc/BRIEF.md
# Fast interrupt source selector

This block holds one control register that chooses a single interrupt source, out of 72 raw level-sensitive lines spread over three banks, and copies that line's level onto a dedicated fast-interrupt output. Software writes a source index and an enable bit. While the enable bit is set and the index names a real source, the output follows that source one clock after it changes. Selecting a source here does not take it off the normal interrupt path. Software should mask the source in its own bank before it routes the source here, or both paths fire.

The index does not count the banks in their natural order. Indices 0 to 31 select bank 1 lines 0 to 31. Indices 32 to 63 select bank 2 lines 0 to 31. Indices 64 to 71 select bank 0 lines 0 to 7. Indices 72 to 127 name no source.

A three-state machine follows the register contents:
- `ST_OFF`: the enable bit is clear.
- `ST_ROUTE`: the block is enabled and the index is valid.
- `ST_PARK`: the block is enabled but the index is out of range.

A register write to the control offset takes the transition that its written enable bit and index call for. These transitions are OFF→ROUTE, OFF→PARK, ROUTE→OFF, ROUTE→PARK, PARK→OFF and PARK→ROUTE, plus a self-loop when the new value maps to the same state. Without such a write the state holds. Only `ST_ROUTE` lets the output register load the selected level. Reset enters `ST_OFF`.

Top module: `fiqsel_top`

## Requirements
- R1: After reset the control register reads 0x00000000 and `fiq_out` is low.
- R2: A write with `bus_wr` high and `bus_addr` = 0x0C stores data bits 7:0. A read at 0x0C returns those 8 bits in bits 7:0, with bit 7 as the enable and bits 6:0 as the index. Bits 31:8 always read 0, whatever was written to them.
- R3: While the stored enable bit (bit 7) is 0, `fiq_out` stays low for every source pattern.
- R4: With the enable set and an index from 0 to 31, `fiq_out` follows `src_bank1[index]`.
- R5: With the enable set and an index from 32 to 63, `fiq_out` follows `src_bank2[index-32]`.
- R6: With the enable set and an index from 64 to 71, `fiq_out` follows `src_bank0[index-64]`.
- R7: With the enable set and an index from 72 to 127, `fiq_out` stays low for every source pattern.
- R8: `fiq_out` shows the selected line's level sampled at the previous rising clock edge, which is one cycle of latency. Lines that are not selected have no effect on it.
- R9: A write to any address other than 0x0C leaves the control register unchanged. A read of any address other than 0x0C returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_bank0 | input | 8 | Raw bank 0 source lines |
| src_bank1 | input | 32 | Raw bank 1 source lines |
| src_bank2 | input | 32 | Raw bank 2 source lines |
| fiq_out | output | 1 | Fast-interrupt output |

## Verification
A wrong state or a corrupted register shows up in one of two ways. It shows up on a read of 0x0C in the same cycle. It also shows up on `fiq_out` one edge after a source toggles. Examples are a machine left in `ST_ROUTE` after the enable is cleared, or the wrong bank chosen for an index. The directed tests toggle the selected line and hold every other line at the opposite level. A mis-decoded index or a bank offset that is off by one then moves the output within one cycle. The indices at each bank edge (0, 31, 32, 63, 64, 71) and at the first and last unused indices (72, 127) are probed explicitly.

// File: rtl/fiqsel_pkg.sv
package fiqsel_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ROUTE = 2'd1,
        ST_PARK  = 2'd2
    } fiq_state_e;
endpackage

// File: rtl/fiqsel_regs.sv
module fiqsel_regs #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 7,
    parameter int CTRL_OFS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ctrl_hit_wr,
    output logic              ctrl_en,
    output logic [IDX_W-1:0]  ctrl_idx
);
    localparam int EN_BIT = IDX_W;
    localparam int PAD_W  = DATA_W - IDX_W - 1;
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(CTRL_OFS);

    logic addr_hit;
    logic unused_wdata_hi;

    assign addr_hit        = (bus_addr == OFS);
    assign ctrl_hit_wr     = bus_wr && addr_hit;
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:EN_BIT+1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en  <= 1'b0;
            ctrl_idx <= '0;
        end else if (ctrl_hit_wr) begin
            ctrl_en  <= bus_wdata[EN_BIT];
            ctrl_idx <= bus_wdata[IDX_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (addr_hit) begin
            bus_rdata = {{PAD_W{1'b0}}, ctrl_en, ctrl_idx};
        end
    end
endmodule

// File: rtl/fiqsel_mux.sv
module fiqsel_mux #(
    parameter int B0_N  = 8,
    parameter int B1_N  = 32,
    parameter int B2_N  = 32,
    parameter int IDX_W = 7
) (
    input  logic [B0_N-1:0]  src_bank0,
    input  logic [B1_N-1:0]  src_bank1,
    input  logic [B2_N-1:0]  src_bank2,
    input  logic [IDX_W-1:0] sel_idx,
    output logic             sel_level
);
    localparam int SRC_N = B0_N + B1_N + B2_N;

    logic [SRC_N-1:0] flat;
    logic [SRC_N-1:0] hit;

    // Index order: bank 1 first, then bank 2, then bank 0
    assign flat = {src_bank0, src_bank2, src_bank1};

    for (genvar g = 0; g < SRC_N; g++) begin : g_decode
        assign hit[g] = flat[g] && (sel_idx == IDX_W'(g));
    end

    assign sel_level = |hit;
endmodule

// File: rtl/fiqsel_fsm.sv
module fiqsel_fsm
    import fiqsel_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int SRC_N = 72
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic             new_en,
    input  logic [IDX_W-1:0] new_idx,
    input  logic             sel_level,
    output fiq_state_e       state,
    output logic             fiq_q
);
    localparam logic [IDX_W:0] LIMIT = SRC_N[IDX_W:0];

    fiq_state_e state_nx;
    fiq_state_e wr_target;

    always_comb begin
        if (!new_en) begin
            wr_target = ST_OFF;
        end else if ({1'b0, new_idx} >= LIMIT) begin
            wr_target = ST_PARK;
        end else begin
            wr_target = ST_ROUTE;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:   if (wr_hit) state_nx = wr_target;
            ST_ROUTE: if (wr_hit) state_nx = wr_target;
            ST_PARK:  if (wr_hit) state_nx = wr_target;
            default:  state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fiq_q <= 1'b0;
        end else begin
            fiq_q <= (state == ST_ROUTE) && sel_level;
        end
    end
endmodule

// File: rtl/fiqsel_top.sv
module fiqsel_top
    import fiqsel_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int B0_N     = 8,
    parameter int B1_N     = 32,
    parameter int B2_N     = 32,
    parameter int CTRL_OFS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [B0_N-1:0]   src_bank0,
    input  logic [B1_N-1:0]   src_bank1,
    input  logic [B2_N-1:0]   src_bank2,
    output logic              fiq_out
);
    localparam int SRC_N = B0_N + B1_N + B2_N;
    localparam int IDX_W = $clog2(SRC_N);

    logic             ctrl_hit_wr;
    logic             ctrl_en;
    logic [IDX_W-1:0] ctrl_idx;
    logic             sel_level;
    fiq_state_e       state;

    fiqsel_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .CTRL_OFS(CTRL_OFS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctrl_hit_wr(ctrl_hit_wr), .ctrl_en(ctrl_en), .ctrl_idx(ctrl_idx)
    );

    fiqsel_mux #(
        .B0_N(B0_N), .B1_N(B1_N), .B2_N(B2_N), .IDX_W(IDX_W)
    ) u_mux (
        .src_bank0(src_bank0), .src_bank1(src_bank1), .src_bank2(src_bank2),
        .sel_idx(ctrl_idx), .sel_level(sel_level)
    );

    fiqsel_fsm #(
        .IDX_W(IDX_W), .SRC_N(SRC_N)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_hit(ctrl_hit_wr),
        .new_en(bus_wdata[IDX_W]), .new_idx(bus_wdata[IDX_W-1:0]),
        .sel_level(sel_level), .state(state), .fiq_q(fiq_out)
    );
endmodule

// File: rtl/fiqsel_checker.sv
module fiqsel_checker #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int B0_N     = 8,
    parameter int B1_N     = 32,
    parameter int B2_N     = 32,
    parameter int CTRL_OFS = 12,
    parameter int IDX_W    = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [B0_N-1:0]   src_bank0,
    input logic [B1_N-1:0]   src_bank1,
    input logic [B2_N-1:0]   src_bank2,
    input logic              ctrl_en,
    input logic [IDX_W-1:0]  ctrl_idx,
    input logic              fiq_out
);
    localparam int W0 = $clog2(B0_N);
    localparam int W1 = $clog2(B1_N);
    localparam int W2 = $clog2(B2_N);
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(CTRL_OFS);
    localparam logic [IDX_W:0] LIM1 = (IDX_W+1)'(B1_N);
    localparam logic [IDX_W:0] LIM2 = (IDX_W+1)'(B1_N + B2_N);
    localparam logic [IDX_W:0] LIM0 = (IDX_W+1)'(B1_N + B2_N + B0_N);

    logic [IDX_W:0]   idx_x;
    logic [IDX_W-1:0] off2_full;
    logic [IDX_W-1:0] off0_full;
    logic [W1-1:0]    off1;
    logic [W2-1:0]    off2;
    logic [W0-1:0]    off0;

    assign idx_x     = {1'b0, ctrl_idx};
    assign off2_full = ctrl_idx - IDX_W'(B1_N);
    assign off0_full = ctrl_idx - IDX_W'(B1_N + B2_N);
    assign off1      = ctrl_idx[W1-1:0];
    assign off2      = off2_full[W2-1:0];
    assign off0      = off0_full[W0-1:0];

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> !fiq_out); // R3
    AST_BANK1_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && idx_x < LIM1) |=> (fiq_out == $past(src_bank1[off1]))); // R4
    AST_BANK2_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && idx_x >= LIM1 && idx_x < LIM2) |=> (fiq_out == $past(src_bank2[off2]))); // R5
    AST_BANK0_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && idx_x >= LIM2 && idx_x < LIM0) |=> (fiq_out == $past(src_bank0[off0]))); // R6
    AST_PARK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_x >= LIM0) |=> !fiq_out); // R7
    AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[DATA_W-1:IDX_W+1] == '0)); // R2
    AST_OTHER_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != OFS) |-> (bus_rdata == '0)); // R9
    AST_OTHER_WRITE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != OFS) |=> ($stable(ctrl_en) && $stable(ctrl_idx))); // R9
endmodule

bind fiqsel_top fiqsel_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .B0_N(B0_N), .B1_N(B1_N), .B2_N(B2_N),
    .CTRL_OFS(CTRL_OFS), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .src_bank0(src_bank0), .src_bank1(src_bank1),
    .src_bank2(src_bank2), .ctrl_en(ctrl_en), .ctrl_idx(ctrl_idx),
    .fiq_out(fiq_out)
);

// File: tb/fiqsel_top_bench.sv
`timescale 1ns/1ps
module fiqsel_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  src_bank0 = '0;
    logic [31:0] src_bank1 = '0;
    logic [31:0] src_bank2 = '0;
    logic        fiq_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    fiqsel_top u_fiqsel_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_bank0(src_bank0),
        .src_bank1(src_bank1), .src_bank2(src_bank2), .fiq_out(fiq_out)
    );

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_addr  = 8'h00;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 8'h00;
    endtask

    // Bench model of the index order: bank1, bank2, bank0
    task automatic drive_only(input int idx, input logic lvl);
        src_bank0 = {8{~lvl}};
        src_bank1 = {32{~lvl}};
        src_bank2 = {32{~lvl}};
        if (idx < 32)      src_bank1[idx]      = lvl;
        else if (idx < 64) src_bank2[idx - 32] = lvl;
        else if (idx < 72) src_bank0[idx - 64] = lvl;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(8'h0C, d);
        check(d == 32'h0, "R1 reset ctrl", d, 32'h0);
        check(fiq_out == 1'b0, "R1 reset fiq", {31'b0, fiq_out}, 32'h0);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        bus_write(8'h0C, 32'hABCD_1285);
        bus_read(8'h0C, d);
        check(d == 32'h85, "R2 readback", d, 32'h85);
        bus_write(8'h0C, 32'hFFFF_FF3A);
        bus_read(8'h0C, d);
        check(d == 32'h3A, "R2 high bits ignored", d, 32'h3A);
    endtask

    task automatic t_disabled();
        bus_write(8'h0C, 32'h0000_0005);
        drive_only(5, 1'b1);
        src_bank0 = '1; src_bank1 = '1; src_bank2 = '1;
        @(negedge clk);
        check(fiq_out == 1'b0, "R3 disabled stays low", {31'b0, fiq_out}, 32'h0);
    endtask

    task automatic route_probe(input int idx, input string req);
        bus_write(8'h0C, 32'h80 | idx);
        drive_only(idx, 1'b1);
        @(negedge clk);
        check(fiq_out == 1'b1, req, {31'b0, fiq_out}, 32'h1);
        drive_only(idx, 1'b0);
        @(negedge clk);
        check(fiq_out == 1'b0, req, {31'b0, fiq_out}, 32'h0);
    endtask

    task automatic t_bank1();
        route_probe(0,  "R4 bank1 idx0");
        route_probe(17, "R4 bank1 idx17");
        route_probe(31, "R4 bank1 idx31");
    endtask

    task automatic t_bank2();
        route_probe(32, "R5 bank2 idx32");
        route_probe(45, "R5 bank2 idx45");
        route_probe(63, "R5 bank2 idx63");
    endtask

    task automatic t_bank0();
        route_probe(64, "R6 bank0 idx64");
        route_probe(70, "R6 bank0 idx70");
        route_probe(71, "R6 bank0 idx71");
    endtask

    task automatic t_park();
        int list[3] = '{72, 100, 127};
        foreach (list[k]) begin
            bus_write(8'h0C, 32'h80 | list[k]);
            src_bank0 = '1; src_bank1 = '1; src_bank2 = '1;
            @(negedge clk);
            check(fiq_out == 1'b0, "R7 unused index low", {31'b0, fiq_out}, 32'h0);
        end
    endtask

    task automatic t_latency();
        bus_write(8'h0C, 32'h80 | 40);
        drive_only(40, 1'b0);
        @(negedge clk);
        src_bank2[8] = 1'b1;
        #1;
        check(fiq_out == 1'b0, "R8 no same-cycle change", {31'b0, fiq_out}, 32'h0);
        @(negedge clk);
        check(fiq_out == 1'b1, "R8 one-cycle latency", {31'b0, fiq_out}, 32'h1);
        src_bank2[9] = 1'b0;
        src_bank1    = '0;
        @(negedge clk);
        check(fiq_out == 1'b1, "R8 other lines no effect", {31'b0, fiq_out}, 32'h1);
    endtask

    task automatic t_other_addr();
        logic [31:0] d;
        bus_write(8'h0C, 32'h0000_0092);
        bus_write(8'h08, 32'h0000_0011);
        bus_write(8'h0D, 32'h0000_0000);
        bus_read(8'h0C, d);
        check(d == 32'h92, "R9 other write ignored", d, 32'h92);
        bus_read(8'h08, d);
        check(d == 32'h0, "R9 other read zero", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_disabled();
        t_bank1();
        t_bank2();
        t_bank0();
        t_park();
        t_latency();
        t_other_addr();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule